// File: doc/BRIEF.md
# Modulator Clock and Control Sequencer

This block sits between a sigma-delta modulator and its decimation filter. It divides the master clock down to a modulator sampling clock. It chooses whether the filter is fed from the modulator bit stream or from a test bit input. It watches the modulator overrange flag and latches an error condition. It also holds the five modulator control bits, which set the amplifier gain and select the input channel.

The block decides when the external filter may run. A power-down request is taken on a falling master clock edge. It stops the modulator clock where it stands and halts filtering. Once power-down ends, filtering stays halted until a sync event arrives. A sync event restarts the decimation period and emits a one-cycle filter-clear pulse. The exception is a sync that lands exactly on the period boundary: the period is already restarting there, so the convolution runs on and no clear pulse is sent. A separate decimator reset input clears the period counter and the filter on demand.

The reset input is synchronous and active high. It clears the error, reloads the control bits from the hardware strap pins and returns the filter to the running state.

Top module: `mod_ctl_sequencer`

## Requirements
- R1: While not powered down, `mclk_o` has a period of DIV master clocks: it is low for DIV/2 cycles and then high for DIV/2 cycles, counting from reset (DIV = 4 by default).
- R2: `filt_bit_o` equals `test_bit_i` when `src_sel_i` is 1 and equals `mod_bit_i` when `src_sel_i` is 0, within the same cycle.
- R3: `ovr_i` is sampled on rising clock edges. After an edge that sees it high, `err_n_o` is 0 and `stat_err_o` is 1, and both stay so until reset, even if `ovr_i` returns low.
- R4: An edge with `rst` high sets `stat_err_o`=0, `err_n_o`=1, `ctl_o`=`cfg_pins_i`, `mclk_o`=0, `filt_clr_o`=0 and `filt_en_o`=1, and restarts the decimation count at zero.
- R5: An edge with `cfg_wr_i` high loads `cfg_wdata_i` into `ctl_o`. Bits [2:0] are the gain or standby code and bits [4:3] are the input channel. Power-down does not change the value held.
- R6: `pwrdn_i` is sampled on falling clock edges. From the falling edge that sees it high, `filt_en_o` is 0 and `mclk_o` holds its level, and the decimation count freezes.
- R7: After power-down is released, `filt_en_o` stays 0 until a sync event is taken.
- R8: A sync event is the first rising edge that sees `sync_i` high after it was low, so a held-high level yields one event. An event that is not aligned drives `filt_clr_o` high for exactly one cycle after that edge, restarts the decimation count at zero and sets `filt_en_o` to 1.
- R9: A sync event taken while filtering runs and the decimation count is at its last value (DEC_LEN-1) produces no `filt_clr_o` pulse, and the count wraps as usual.
- R10: An edge with `dec_rst_i` high drives `filt_clr_o` high for the following cycle and restarts the decimation count at zero.
- R11: A sync event taken while powered down is ignored: it gives no clear pulse and leaves filtering halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_i | input | 1 | Power-down request, sampled on falling edges |
| sync_i | input | 1 | Sync request, edge detected |
| dec_rst_i | input | 1 | Decimator reset |
| src_sel_i | input | 1 | Filter source select: 1 = test bit, 0 = modulator bit |
| mod_bit_i | input | 1 | Modulator bit stream |
| test_bit_i | input | 1 | Test bit stream |
| ovr_i | input | 1 | Modulator overrange flag |
| cfg_pins_i | input | 5 | Strap values loaded into the control bits on reset |
| cfg_wr_i | input | 1 | Control bit write strobe |
| cfg_wdata_i | input | 5 | Control bit write data |
| mclk_o | output | 1 | Modulator sampling clock |
| filt_bit_o | output | 1 | Selected filter input bit |
| err_n_o | output | 1 | Active-low error output |
| stat_err_o | output | 1 | Status error bit |
| filt_en_o | output | 1 | Filter convolution enable |
| filt_clr_o | output | 1 | One-cycle filter clear pulse |
| ctl_o | output | 5 | Modulator control bits: [4:3] channel, [2:0] gain |

## Verification
The filter source output is combinational and is due in the same cycle as its select and data inputs. The error, control bits, clear pulse, divider and decimation count each change one rising edge after the inputs they depend on are sampled. The enable drops, and the divider freezes, from the falling edge that samples power-down. The bench drives inputs 1 ns after each rising edge and compares every output 3 ns after it, which falls after the intervening falling edge. Its behavioural model updates the power-down state on falling edges and everything else on rising edges, so each output is compared in exactly the cycle it is due. The aligned sync is placed by waiting until the model's count reads DEC_LEN-1 before raising the sync input.

// File: rtl/modseq_pkg.sv
package modseq_pkg;

    typedef struct packed {
        logic [1:0] chan;
        logic [2:0] gain;
    } ctl_t;

    typedef enum logic {
        FLT_RUN  = 1'b0,
        FLT_HALT = 1'b1
    } flt_state_t;

    function automatic int unsigned next_mod(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n > 2) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/modseq_clkdiv.sv
module modseq_clkdiv
    import modseq_pkg::*;
#(
    parameter int unsigned DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output logic mclk
);
    localparam int unsigned CW   = cnt_width(DIV);
    localparam int unsigned HALF = DIV / 2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!hold) begin
            cnt_q <= CW'(next_mod(32'(cnt_q), DIV));
        end
    end

    assign mclk = (32'(cnt_q) >= HALF);

    // R6: the sampling clock does not move while powered down
    a_r6_mclk_frozen: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(mclk));

endmodule

// File: rtl/modseq_errflag.sv
module modseq_errflag (
    input  logic clk,
    input  logic rst,
    input  logic ovr,
    output logic err
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (ovr) begin
            err_q <= 1'b1;
        end
    end

    assign err = err_q;

    // R3: an overrange sample sets the flag on the next edge
    a_r3_ovr_sets: assert property (@(posedge clk) disable iff (rst)
        ovr |=> err);

    // R3: the flag stays set until reset
    a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

endmodule

// File: rtl/modseq_cfgreg.sv
module modseq_cfgreg
    import modseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_t pins,
    input  logic wr,
    input  ctl_t wdata,
    output ctl_t q
);
    ctl_t q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= pins;
        end else if (wr) begin
            q_r <= wdata;
        end
    end

    assign q = q_r;

    // R5: without a write the control bits keep their value
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(q));

endmodule

// File: rtl/modseq_syncctl.sv
module modseq_syncctl
    import modseq_pkg::*;
#(
    parameter int unsigned DEC_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic pd,
    input  logic sync_in,
    input  logic dec_rst,
    output logic filt_en,
    output logic filt_clr
);
    localparam int unsigned DW   = cnt_width(DEC_LEN);
    localparam int unsigned LAST = DEC_LEN - 1;

    logic          sync_d;
    flt_state_t    state_q;
    logic [DW-1:0] cnt_q;
    logic          clr_q;
    logic          sync_ev;
    logic          sync_go;
    logic          running;
    logic          aligned;
    logic          restart;

    assign sync_ev = sync_in && !sync_d;
    assign sync_go = sync_ev && !pd;
    assign running = (state_q == FLT_RUN) && !pd;
    assign aligned = running && (32'(cnt_q) == LAST);
    assign restart = sync_go && !aligned;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_d  <= 1'b0;
            state_q <= FLT_RUN;
            cnt_q   <= '0;
            clr_q   <= 1'b0;
        end else begin
            sync_d <= sync_in;
            clr_q  <= dec_rst || restart;
            if (pd) begin
                state_q <= FLT_HALT;
            end else if (sync_go) begin
                state_q <= FLT_RUN;
            end
            if (dec_rst || restart) begin
                cnt_q <= '0;
            end else if (running) begin
                cnt_q <= DW'(next_mod(32'(cnt_q), DEC_LEN));
            end
        end
    end

    assign filt_en  = running;
    assign filt_clr = clr_q;

    // R9: a sync on the period boundary sends no clear
    a_r9_aligned_no_clr: assert property (@(posedge clk) disable iff (rst)
        (sync_go && aligned && !dec_rst) |=> !filt_clr);

    // R10: decimator reset always clears the filter
    a_r10_decrst_clr: assert property (@(posedge clk) disable iff (rst)
        dec_rst |=> filt_clr);

    // R7: filtering only resumes through a sync event
    a_r7_resume_by_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_en) |-> $past(sync_go));

    // R11: a sync while powered down changes nothing
    a_r11_pd_sync_ignored: assert property (@(posedge clk) disable iff (rst)
        (pd && !dec_rst) |=> !filt_clr);

endmodule

// File: rtl/mod_ctl_sequencer.sv
module mod_ctl_sequencer
    import modseq_pkg::*;
#(
    parameter int unsigned DIV     = 4,
    parameter int unsigned DEC_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwrdn_i,
    input  logic       sync_i,
    input  logic       dec_rst_i,
    input  logic       src_sel_i,
    input  logic       mod_bit_i,
    input  logic       test_bit_i,
    input  logic       ovr_i,
    input  logic [4:0] cfg_pins_i,
    input  logic       cfg_wr_i,
    input  logic [4:0] cfg_wdata_i,
    output logic       mclk_o,
    output logic       filt_bit_o,
    output logic       err_n_o,
    output logic       stat_err_o,
    output logic       filt_en_o,
    output logic       filt_clr_o,
    output logic [4:0] ctl_o
);
    logic pd_q;
    logic err;
    ctl_t ctl;

    // power-down request is taken on the falling edge
    always_ff @(negedge clk) begin
        if (rst) begin
            pd_q <= 1'b0;
        end else begin
            pd_q <= pwrdn_i;
        end
    end

    modseq_clkdiv #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .hold (pd_q),
        .mclk (mclk_o)
    );

    modseq_errflag u_err (
        .clk (clk),
        .rst (rst),
        .ovr (ovr_i),
        .err (err)
    );

    modseq_cfgreg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .pins  (ctl_t'(cfg_pins_i)),
        .wr    (cfg_wr_i),
        .wdata (ctl_t'(cfg_wdata_i)),
        .q     (ctl)
    );

    modseq_syncctl #(.DEC_LEN(DEC_LEN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pd       (pd_q),
        .sync_in  (sync_i),
        .dec_rst  (dec_rst_i),
        .filt_en  (filt_en_o),
        .filt_clr (filt_clr_o)
    );

    assign filt_bit_o = src_sel_i ? test_bit_i : mod_bit_i;
    assign err_n_o    = !err;
    assign stat_err_o = err;
    assign ctl_o      = ctl;

    // R3: the two error outputs always agree
    a_r3_err_pair: assert property (@(posedge clk) disable iff (rst)
        err_n_o != stat_err_o);

endmodule

// File: tb/mod_ctl_sequencer_tb_top.sv
module mod_ctl_sequencer_tb_top;
    localparam int DIV  = 4;
    localparam int DECL = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       pwrdn_i = 0, sync_i = 0, dec_rst_i = 0, src_sel_i = 0;
    logic       mod_bit_i = 0, test_bit_i = 0, ovr_i = 0, cfg_wr_i = 0;
    logic [4:0] cfg_pins_i = 5'b10110, cfg_wdata_i = 5'b0;
    logic       mclk_o, filt_bit_o, err_n_o, stat_err_o, filt_en_o, filt_clr_o;
    logic [4:0] ctl_o;

    mod_ctl_sequencer #(.DIV(DIV), .DEC_LEN(DECL)) dut_i (
        .clk(clk), .rst(rst), .pwrdn_i(pwrdn_i), .sync_i(sync_i),
        .dec_rst_i(dec_rst_i), .src_sel_i(src_sel_i), .mod_bit_i(mod_bit_i),
        .test_bit_i(test_bit_i), .ovr_i(ovr_i), .cfg_pins_i(cfg_pins_i),
        .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .mclk_o(mclk_o),
        .filt_bit_o(filt_bit_o), .err_n_o(err_n_o), .stat_err_o(stat_err_o),
        .filt_en_o(filt_en_o), .filt_clr_o(filt_clr_o), .ctl_o(ctl_o)
    );

    // behavioural reference model
    int         m_pd = 0, m_div = 0, m_err = 0, m_syncd = 0, m_halt = 0;
    int         m_cnt = 0, m_clr = 0;
    logic [4:0] m_cfg = 5'b0;

    int    n_chk = 0, n_err = 0;
    string phase = "R4";
    bit    done = 0;

    always @(negedge clk) m_pd = rst ? 0 : int'(pwrdn_i);

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_err = 0; m_syncd = 0; m_halt = 0;
            m_cnt = 0; m_clr = 0; m_cfg = cfg_pins_i;
        end else begin
            int ev, go, en, al;
            ev = (sync_i && !m_syncd) ? 1 : 0;
            go = (ev != 0 && m_pd == 0) ? 1 : 0;
            en = (m_halt == 0 && m_pd == 0) ? 1 : 0;
            al = (en != 0 && m_cnt == DECL - 1) ? 1 : 0;
            m_clr = (dec_rst_i || (go != 0 && al == 0)) ? 1 : 0;
            if (dec_rst_i || (go != 0 && al == 0)) m_cnt = 0;
            else if (en != 0) m_cnt = (m_cnt + 1) % DECL;
            if (m_pd != 0) m_halt = 1;
            else if (go != 0) m_halt = 0;
            if (ovr_i) m_err = 1;
            if (m_pd == 0) m_div = (m_div + 1) % DIV;
            m_syncd = int'(sync_i);
            if (cfg_wr_i) m_cfg = cfg_wdata_i;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s (phase %s) at %0t: actual=%0d expected=%0d",
                     tag, phase, $time, act, exp);
        end
    endtask

    // compare every output 3 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (!done) begin
                chk(mclk_o === (m_div >= DIV / 2), "R1 mclk_o", int'(mclk_o), int'(m_div >= DIV / 2));
                chk(filt_bit_o === (src_sel_i ? test_bit_i : mod_bit_i), "R2 filt_bit_o",
                    int'(filt_bit_o), int'(src_sel_i ? test_bit_i : mod_bit_i));
                chk(stat_err_o === (m_err != 0), "R3 stat_err_o", int'(stat_err_o), m_err);
                chk(err_n_o === (m_err == 0), "R3 err_n_o", int'(err_n_o), int'(m_err == 0));
                chk(ctl_o === m_cfg, "R5 ctl_o", int'(ctl_o), int'(m_cfg));
                chk(filt_en_o === (m_halt == 0 && m_pd == 0), "R7 filt_en_o",
                    int'(filt_en_o), int'(m_halt == 0 && m_pd == 0));
                chk(filt_clr_o === (m_clr != 0), "R8 filt_clr_o", int'(filt_clr_o), m_clr);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired in phase %s", phase);
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // R4: reset loads strap pins, clears error
        tick(4);
        rst = 1'b0;
        phase = "R1";
        tick(20);

        // R2: source select patterns
        phase = "R2";
        for (int i = 0; i < 8; i++) begin
            src_sel_i  = i[0];
            mod_bit_i  = i[1];
            test_bit_i = ~i[1] ^ i[2];
            tick(1);
        end

        // R3: single overrange sample, then sticky
        phase = "R3";
        ovr_i = 1'b1; tick(1);
        ovr_i = 1'b0; tick(10);

        // R5: control bit write
        phase = "R5";
        cfg_wdata_i = 5'b01011; cfg_wr_i = 1'b1; tick(1);
        cfg_wr_i = 1'b0; tick(5);

        // R4: reset mid-run clears error and reloads new pins
        phase = "R4";
        cfg_pins_i = 5'b00101; rst = 1'b1; tick(2);
        rst = 1'b0; tick(3);

        // R8: unaligned sync held high gives one event
        phase = "R8";
        while (m_cnt != 5) tick(1);
        sync_i = 1'b1; tick(6);
        sync_i = 1'b0; tick(4);

        // R9: sync on the boundary count
        phase = "R9";
        while (m_cnt != DECL - 1) tick(1);
        sync_i = 1'b1; tick(1);
        sync_i = 1'b0; tick(DECL + 2);

        // R10: decimator reset pulse
        phase = "R10";
        dec_rst_i = 1'b1; tick(1);
        dec_rst_i = 1'b0; tick(6);

        // R6: power-down freezes the clock; R11: sync ignored inside it
        phase = "R6";
        pwrdn_i = 1'b1; tick(5);
        phase = "R11";
        sync_i = 1'b1; tick(2);
        sync_i = 1'b0;
        cfg_wdata_i = 5'b11000; cfg_wr_i = 1'b1; tick(1);
        cfg_wr_i = 1'b0; tick(4);

        // R7: release, stay halted, resume on sync
        phase = "R7";
        pwrdn_i = 1'b0; tick(10);
        sync_i = 1'b1; tick(1);
        sync_i = 1'b0; tick(20);

        // power-down with clock high, then a mid-cycle release
        phase = "R6";
        while (m_div != DIV / 2) tick(1);
        pwrdn_i = 1'b1; tick(7);
        pwrdn_i = 1'b0; tick(3);
        phase = "R7";
        sync_i = 1'b1; tick(2);
        sync_i = 1'b0; tick(10);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule